// File: doc/BRIEF.md
# Two-Stage Saturating Multiply-Accumulator

This block multiplies two signed two's complement operands on every clock cycle and either passes the product through or adds it to a running sum. The pipeline has two register stages. The first stage only forms radix-4 Booth partial-product rows and captures them, with their negation correction bits. The second stage sign-extends those rows and folds them, the correction bits and the current running sum into one carry-save reduction. It then does one carry-propagate add into a wide accumulator and clamps the result to the output width.

Product summation and accumulation share the same second-stage adder, so no completion cycle is needed. A steady stream of operand pairs yields one result per clock after a fill of two edges. The accumulator holds guard bits above the product width, so a sum can leave the output range and come back without losing precision. The output shows the clamped view of that sum together with a sticky overflow indication.

Top module: `mac_sat_pipe`

## Requirements
- R1: While reset is held and right after it is released, out_valid is 0, out_acc is 0 and out_ovf is 0.
- R2: An operand pair presented with in_valid high at rising edge k gives out_valid high after edge k+1, and its result is on out_acc after that same edge. Back-to-back pairs give one result per cycle.
- R3: With in_mode = 0 (multiply-only), the accumulator becomes the signed product in_a × in_b, and the previous sum is ignored.
- R4: With in_mode = 1 (multiply-accumulate), the accumulator becomes the previous accumulator plus in_a × in_b, wrapping as a two's complement number of 2·OP_W+GUARD_W bits.
- R5: in_clear = 1 together with in_valid makes that pair start a new sum: the accumulator becomes the product alone in either mode, and the sticky overflow flag is recomputed from this result only. A following pair can accumulate on the next cycle with no gap.
- R6: When in_valid is low, in_a, in_b, in_mode and in_clear have no effect. out_acc and out_ovf keep their values and out_valid is 0 one edge later.
- R7: If the accumulator bits from position 2·OP_W−1 upward are not all equal, out_acc shows the largest positive value (0 then all ones) for a non-negative sum, or the most negative value (1 then all zeros) for a negative sum. Otherwise out_acc equals the low 2·OP_W bits of the accumulator.
- R8: out_ovf rises after any update whose accumulator value is outside the out_acc range. It stays high until a pair with in_clear, or a reset.
- R9: The guard bits keep the sum exact while it is clamped. Once the sum returns into range, out_acc shows the exact sum again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | OP_W | Signed multiplicand |
| in_b | input | OP_W | Signed multiplier (Booth-recoded) |
| in_mode | input | 1 | 0 = multiply-only, 1 = multiply-accumulate |
| in_clear | input | 1 | Start a new sum with this pair |
| out_valid | output | 1 | A new result was written on the last edge |
| out_acc | output | 2·OP_W | Saturated view of the accumulator |
| out_ovf | output | 1 | Sticky out-of-range flag |

## Verification
The interesting collision is a clear that arrives on the very cycle it must act: it discards the running sum and resets the sticky flag in the same cycle that a fresh product is added. The bench provokes this in two ways. It sends a clear directly after a run that drove the sum out of range. It also interleaves clears with back-to-back accumulations, both in a pseudo-random walk and in directed sequences. An arithmetic model in the bench predicts the wide sum, the clamped view and the flag on every cycle, and each is judged against it. A clear must win over a flag that is already set, and an accumulation in the next cycle must build on the product alone.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

   typedef enum logic {
      MODE_MUL = 1'b0,
      MODE_MAC = 1'b1
   } mac_mode_e;

   // one Booth digit: magnitude select and sign
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_sel_t;

   // radix-4 recoding of an overlapping multiplier bit triplet {hi, mid, lo}
   function automatic booth_sel_t booth_decode(input logic [2:0] trip);
      booth_sel_t s;
      s.one = trip[1] ^ trip[0];
      s.two = (trip == 3'b011) || (trip == 3'b100);
      s.neg = trip[2] & ~(trip[1] & trip[0]);
      return s;
   endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
   import mac_sat_pkg::*;
#(
   parameter int OP_W = 16
) (
   input  logic [OP_W-1:0]                  mcand,
   input  logic [OP_W-1:0]                  mplier,
   output logic [OP_W/2-1:0][OP_W:0]        rows,
   output logic [OP_W/2-1:0]                neg
);
   localparam int N_ROWS = OP_W / 2;
   localparam int ROW_W  = OP_W + 1;

   logic [OP_W:0]  mplier_ext;
   logic [ROW_W-1:0] mcand_x1;
   logic [ROW_W-1:0] mcand_x2;

   assign mplier_ext = {mplier, 1'b0};
   assign mcand_x1   = {mcand[OP_W-1], mcand};
   assign mcand_x2   = {mcand, 1'b0};

   for (genvar g = 0; g < N_ROWS; g++) begin : g_row
      booth_sel_t       sel;
      logic [ROW_W-1:0] mag;

      assign sel = booth_decode(mplier_ext[2*g+2 -: 3]);

      always_comb begin
         if (sel.two)
            mag = mcand_x2;
         else if (sel.one)
            mag = mcand_x1;
         else
            mag = '0;
      end

      // negative digit: store the ones' complement, the +1 goes in stage two
      assign rows[g] = sel.neg ? ~mag : mag;
      assign neg[g]  = sel.neg;
   end

endmodule

// File: rtl/pp_compressor.sv
module pp_compressor #(
   parameter int OP_W         = 16,
   parameter int ACC_W        = 40,
   parameter int REDUCE_STYLE = 0
) (
   input  logic [OP_W/2-1:0][OP_W:0]  rows,
   input  logic [OP_W/2-1:0]          neg,
   input  logic [ACC_W-1:0]           acc_in,
   output logic [ACC_W-1:0]           sum
);
   localparam int N_ROWS = OP_W / 2;
   localparam int ROW_W  = OP_W + 1;
   localparam int EXT_W  = ACC_W - ROW_W;
   localparam int NOPS   = N_ROWS + 2;

   logic [NOPS-1:0][ACC_W-1:0] ops;
   logic [ACC_W-1:0]           corr;

   // sign-extended, weighted Booth rows
   for (genvar g = 0; g < N_ROWS; g++) begin : g_ext
      assign ops[g] = {{EXT_W{rows[g][ROW_W-1]}}, rows[g]} << (2 * g);
   end

   // correction bits sit on disjoint even positions, so they share one word
   always_comb begin
      corr = '0;
      for (int i = 0; i < N_ROWS; i++)
         corr[2*i] = neg[i];
   end

   assign ops[N_ROWS]   = corr;
   assign ops[N_ROWS+1] = acc_in;

   if (REDUCE_STYLE == 0) begin : g_csa
      logic [NOPS-2:0][ACC_W-1:0] s_ch;
      logic [NOPS-2:0][ACC_W-1:0] c_ch;

      assign s_ch[0] = ops[0];
      assign c_ch[0] = ops[1];

      for (genvar k = 1; k <= NOPS - 2; k++) begin : g_lvl
         assign s_ch[k] = s_ch[k-1] ^ c_ch[k-1] ^ ops[k+1];
         assign c_ch[k] = ((s_ch[k-1] & c_ch[k-1]) |
                           (s_ch[k-1] & ops[k+1])  |
                           (c_ch[k-1] & ops[k+1])) << 1;
      end

      assign sum = s_ch[NOPS-2] + c_ch[NOPS-2];
   end else begin : g_direct
      always_comb begin
         sum = '0;
         for (int k = 0; k < NOPS; k++)
            sum = sum + ops[k];
      end
   end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
   parameter int ACC_W = 40,
   parameter int OUT_W = 32
) (
   input  logic [ACC_W-1:0] acc,
   output logic [OUT_W-1:0] sat,
   output logic             out_of_range
);
   localparam int TOP_W = ACC_W - OUT_W + 1;
   localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

   logic [TOP_W-1:0] top_bits;

   assign top_bits     = acc[ACC_W-1:OUT_W-1];
   assign out_of_range = !((&top_bits) || !(|top_bits));

   always_comb begin
      if (!out_of_range)
         sat = acc[OUT_W-1:0];
      else if (acc[ACC_W-1])
         sat = NEG_LIM;
      else
         sat = POS_LIM;
   end

endmodule

// File: rtl/mac_sat_pipe.sv
module mac_sat_pipe
   import mac_sat_pkg::*;
#(
   parameter int OP_W         = 16,
   parameter int GUARD_W      = 8,
   parameter int REDUCE_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_a,
   input  logic [OP_W-1:0]   in_b,
   input  logic              in_mode,
   input  logic              in_clear,
   output logic              out_valid,
   output logic [2*OP_W-1:0] out_acc,
   output logic              out_ovf
);
   localparam int PROD_W = 2 * OP_W;
   localparam int ACC_W  = PROD_W + GUARD_W;
   localparam int N_ROWS = OP_W / 2;
   localparam int ROW_W  = OP_W + 1;
   localparam logic [PROD_W-1:0] POS_LIM = {1'b0, {(PROD_W-1){1'b1}}};
   localparam logic [PROD_W-1:0] NEG_LIM = {1'b1, {(PROD_W-1){1'b0}}};

   if (OP_W < 4 || (OP_W % 2) != 0) begin : g_chk_op
      $error("mac_sat_pipe: OP_W must be even and at least 4");
   end
   if (GUARD_W < 1) begin : g_chk_guard
      $error("mac_sat_pipe: GUARD_W must be at least 1");
   end
   if (REDUCE_STYLE < 0 || REDUCE_STYLE > 1) begin : g_chk_style
      $error("mac_sat_pipe: REDUCE_STYLE must be 0 or 1");
   end

   // ---------------- stage one: partial-product rows only ----------------
   logic [N_ROWS-1:0][ROW_W-1:0] pp_rows;
   logic [N_ROWS-1:0]            pp_neg;

   booth_pp_gen #(.OP_W(OP_W)) u_booth (
      .mcand  (in_a),
      .mplier (in_b),
      .rows   (pp_rows),
      .neg    (pp_neg)
   );

   logic                         s1_valid;
   mac_mode_e                    s1_mode;
   logic                         s1_clear;
   logic [N_ROWS-1:0][ROW_W-1:0] s1_rows;
   logic [N_ROWS-1:0]            s1_neg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mode  <= MODE_MUL;
         s1_clear <= 1'b0;
         s1_rows  <= '0;
         s1_neg   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_mode  <= mac_mode_e'(in_mode);
            s1_clear <= in_clear;
            s1_rows  <= pp_rows;
            s1_neg   <= pp_neg;
         end
      end
   end

   // ---------------- stage two: merge, add, clamp ----------------
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_feed;
   logic [ACC_W-1:0]  acc_nxt;
   logic [PROD_W-1:0] sat_nxt;
   logic              oor_nxt;
   logic              restart;

   assign restart  = s1_clear || (s1_mode == MODE_MUL);
   assign acc_feed = restart ? '0 : acc_q;

   pp_compressor #(
      .OP_W         (OP_W),
      .ACC_W        (ACC_W),
      .REDUCE_STYLE (REDUCE_STYLE)
   ) u_reduce (
      .rows   (s1_rows),
      .neg    (s1_neg),
      .acc_in (acc_feed),
      .sum    (acc_nxt)
   );

   sat_clamp #(.ACC_W(ACC_W), .OUT_W(PROD_W)) u_sat (
      .acc          (acc_nxt),
      .sat          (sat_nxt),
      .out_of_range (oor_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         out_acc   <= '0;
         out_ovf   <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            acc_q   <= acc_nxt;
            out_acc <= sat_nxt;
            out_ovf <= (s1_clear ? 1'b0 : out_ovf) | oor_nxt;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r2_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> ($stable(out_acc) && $stable(out_ovf) && !out_valid));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ovf && !(s1_valid && s1_clear)) |=> out_ovf);

   // a single product always fits the output field, so a restart drops the flag
   a_r5_clear_drops_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_clear) |=> !out_ovf);

   a_r7_rise_is_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_ovf) |-> (out_acc == POS_LIM || out_acc == NEG_LIM));

endmodule

// File: tb/test_mac_sat_pipe.sv
`timescale 1ns/1ps
module test_mac_sat_pipe;
   localparam int OPW  = 6;
   localparam int GW   = 3;
   localparam int PW   = 2 * OPW;
   localparam int AW   = PW + GW;
   localparam longint MAXP = (longint'(1) << (PW - 1)) - 1;
   localparam longint MINP = -(longint'(1) << (PW - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            in_valid, in_mode, in_clear;
   logic [OPW-1:0]  in_a, in_b;
   logic            out_valid;
   logic [PW-1:0]   out_acc;
   logic            out_ovf;

   mac_sat_pipe #(.OP_W(OPW), .GUARD_W(GW), .REDUCE_STYLE(0)) i_mac_sat_pipe (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_mode(in_mode), .in_clear(in_clear), .out_valid(out_valid),
      .out_acc(out_acc), .out_ovf(out_ovf)
   );

   int vectors = 0;
   int errors  = 0;

   // arithmetic model
   longint m_acc = 0;
   bit     m_ovf = 0;
   bit     m_valid = 0;
   bit     p_v = 0, p_m = 0, p_c = 0;
   longint p_prod = 0;

   function automatic longint wrapw(input longint x);
      longint span, r;
      span = longint'(1) << AW;
      r = x % span;
      if (r < 0) r += span;
      if (r >= span / 2) r -= span;
      return r;
   endfunction

   function automatic longint satv(input longint x);
      if (x > MAXP) return MAXP;
      if (x < MINP) return MINP;
      return x;
   endfunction

   task automatic check(input string tag);
      longint act;
      act = longint'($signed(out_acc));
      vectors++;
      if (out_valid !== m_valid || act != satv(m_acc) || out_ovf !== m_ovf) begin
         errors++;
         $display("FAIL %s: actual valid=%0b acc=%0d ovf=%0b expected valid=%0b acc=%0d ovf=%0b",
                  tag, out_valid, act, out_ovf, m_valid, satv(m_acc), m_ovf);
      end
   endtask

   task automatic cyc(input bit v, input logic signed [OPW-1:0] a,
                      input logic signed [OPW-1:0] b, input bit mode,
                      input bit clr, input string tag);
      longint nv;
      in_valid = v; in_a = a; in_b = b; in_mode = mode; in_clear = clr;
      @(posedge clk);
      if (p_v) begin
         nv = (p_c || !p_m) ? p_prod : m_acc + p_prod;
         m_acc = wrapw(nv);
         m_ovf = (p_c ? 1'b0 : m_ovf) | (m_acc > MAXP || m_acc < MINP);
      end
      m_valid = p_v;
      p_v = v;
      if (v) begin
         p_m = mode; p_c = clr;
         p_prod = longint'(a) * longint'(b);
      end
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL R2: watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      bit [31:0] lf;
      in_valid = 0; in_a = '0; in_b = '0; in_mode = 0; in_clear = 0;
      repeat (3) @(negedge clk);
      check("R1");                           // R1: state held in reset
      rst_n = 1'b1;
      check("R1");

      // R3 and R2: exhaustive multiply-only sweep, back to back
      for (int i = -(1 << (OPW - 1)); i < (1 << (OPW - 1)); i++)
         for (int j = -(1 << (OPW - 1)); j < (1 << (OPW - 1)); j++)
            cyc(1, OPW'(i), OPW'(j), 0, 0, "R3");

      // R5: clears inside a back-to-back accumulation
      cyc(1, 5, 5, 1, 1, "R5");
      cyc(1, 3, 3, 1, 0, "R5");
      cyc(1, 2, 2, 1, 1, "R5");
      cyc(1, 1, 1, 1, 0, "R5");
      cyc(1, -3, 7, 0, 1, "R5");

      // R7, R8, R9: positive overflow and return into range
      cyc(1, -32, -32, 1, 1, "R8");
      cyc(1, -32, -32, 1, 0, "R7");
      cyc(1, -32, -32, 1, 0, "R7");
      cyc(1, -32, 31, 1, 0, "R9");
      cyc(1, -32, 31, 1, 0, "R9");
      cyc(1, 0, 0, 0, 0, "R8");            // multiply-only keeps the flag

      // R6: idle cycles with toggling controls and data
      cyc(0, 17, -9, 1, 1, "R6");
      cyc(0, -1, -1, 0, 1, "R6");
      cyc(0, 31, 31, 1, 0, "R6");
      cyc(0, 0, 0, 0, 0, "R6");

      // R7 negative clamp, then a clear in the cycle after the overflow (R5)
      cyc(1, -32, 31, 1, 1, "R5");
      cyc(1, -32, 31, 1, 0, "R7");
      cyc(1, -32, 31, 1, 0, "R7");
      cyc(1, 4, -4, 1, 1, "R5");
      cyc(1, 4, 4, 1, 0, "R4");

      // R4 and R6: pseudo-random walk
      lf = 32'h1ACE_B00C;
      for (int n = 0; n < 2000; n++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         cyc(lf[0] | lf[1], lf[13:8], lf[19:14], lf[2] | lf[3],
             lf[7:4] == 4'd0, "R4");
      end
      cyc(0, 0, 0, 0, 0, "R6");
      cyc(0, 0, 0, 0, 0, "R6");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule